// File: doc/BRIEF.md
# Event Counter with Selectable Timebase and Guarded Mode Register

This block is a 16-bit up-counter that advances on one of several selectable count enables: fixed divisions of the system clock, the undivided system clock, a timer overflow pulse, falling edges on an external event pin, or an external clock divided by eight. An 8-bit mode register, reached over a small register bus, picks the count source. The same register can stop counting while the CPU reports idle and can let the overflow flag raise an interrupt request.

The mode register also carries a watchdog-enable bit and a lock bit. While watchdog enable is set, the other configuration bits are frozen. Once the lock is set, watchdog enable cannot be cleared until reset. The block only drives the watchdog-enable level out. Comparing against it and generating resets is done elsewhere.

The register bus is a single-cycle write strobe with a combinational read. Address 0 is the mode register, address 1 is the count low byte, address 2 is the count high byte, and address 3 holds the overflow flag in bit 0. All pins are plain control and status pins, so there is no back-pressure.

Top module: `evt_counter_ctrl`

## Requirements
- R1: After reset, the mode register reads 0x40 (watchdog enable set, all other bits 0), the count is 0x0000, the overflow flag is 0, irq is 0 and wd_enable is 1.
- R2: The mode register fields are: bit 7 idle suspend, bit 6 watchdog enable, bit 5 lock, bits 3:1 source select, bit 0 interrupt enable. Bit 4 always reads 0, and a write of 1 to bit 4 leaves it at 0.
- R3: Select 000 advances the count once every 12 system clocks, 001 once every 4 system clocks, and 100 on every system clock.
- R4: Select 010 advances the count once per cycle in which tmr_ovf_in is high. Selects 110 and 111 hold the count, and these codes read back unchanged.
- R5: Select 011 advances the count once per high-to-low transition of evt_pin, after a two-flop synchronizer. Events spaced four system clocks apart are all counted.
- R6: Select 101 advances the count once per eight rising edges of ext_clk, after a two-flop synchronizer.
- R7: With bit 7 set, the count holds while cpu_idle is 1. With bit 7 clear, cpu_idle has no effect.
- R8: The count wraps from 0xFFFF to 0x0000 and sets the sticky overflow flag. Only a write to address 3 with bit 0 = 0 clears the flag. If an overflow happens in the same cycle as that write, the set wins.
- R9: irq is 1 exactly when the overflow flag is 1 and mode bit 0 is 1.
- R10: While watchdog enable is 1, a mode write leaves bits 7 and 3:0 unchanged. A write with bit 6 = 0 and no lock clears watchdog enable, and later writes then update every field.
- R11: The lock bit, once set, stays set until reset. While the lock is set, watchdog enable cannot be cleared.
- R12: A write to address 1 or 2 replaces that byte of the count. This takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tmr_ovf_in | input | 1 | One-cycle timer overflow pulse |
| evt_pin | input | 1 | Asynchronous external event pin |
| ext_clk | input | 1 | Asynchronous external clock |
| cpu_idle | input | 1 | CPU idle indication |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wd_enable | output | 1 | Watchdog enable level |

## Verification
The bench clears the reset-time watchdog enable before configuring anything. It then shows that a write made while enable is set leaves the mode unchanged; a design that ignored the freeze would pick up the new select code. Each source is measured over a window that is a whole multiple of its period, so a wrong division or a doubled edge detect shows up as a wrong count. For the external clock, the bench also checks that seven extra edges give no advance and that the eighth does. The bench checks the wrap from 0xFFFF, shows that writing 1 to the flag does not clear it, shows that irq stays low while its enable is off, and shows that a locked enable survives a clearing write. A design that dropped the lock, or that let a reserved code count, would leave a visible difference in the mode read-back or in the count.

// File: rtl/ectl_pkg.sv
package ectl_pkg;
  typedef enum logic [2:0] {
    TB_DIV_SLOW = 3'b000,
    TB_DIV_FAST = 3'b001,
    TB_TPULSE   = 3'b010,
    TB_EVT_FALL = 3'b011,
    TB_SYSCLK   = 3'b100,
    TB_EXT_DIV  = 3'b101,
    TB_RSV_A    = 3'b110,
    TB_RSV_B    = 3'b111
  } tb_sel_e;

  // mode register bit positions (decoded by neighbours, so fixed)
  localparam int MB_IDLE = 7;
  localparam int MB_WDEN = 6;
  localparam int MB_LOCK = 5;
  localparam int MB_ZERO = 4;
  localparam int MB_IEN  = 0;
  localparam logic [7:0] MODE_RESET = 8'h40;
endpackage

// File: rtl/ectl_sync.sv
module ectl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate
  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ectl_timebase.sv
module ectl_timebase
  import ectl_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tb_sel_e sel,
  input  logic    tmr_pulse,
  input  logic    evt_pin,
  input  logic    ext_clk,
  output logic    tick
);
  localparam int SW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam int FW = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
  localparam int EW = (EXT_DIV  > 1) ? $clog2(EXT_DIV)  : 1;

  logic [SW-1:0] slow_q;
  logic [FW-1:0] fast_q;
  logic [EW-1:0] ext_q;
  logic slow_tick, fast_tick, ext_tick;
  logic evt_s, evt_d, evt_fall;
  logic ext_s, ext_d, ext_rise;

  assign slow_tick = (slow_q == SW'(DIV_SLOW - 1));
  assign fast_tick = (fast_q == FW'(DIV_FAST - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      slow_q <= slow_tick ? '0 : slow_q + 1'b1;
      fast_q <= fast_tick ? '0 : fast_q + 1'b1;
    end
  end

  ectl_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .d(evt_pin), .q(evt_s));
  ectl_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s));

  assign evt_fall = evt_d & ~evt_s;
  assign ext_rise = ext_s & ~ext_d;
  assign ext_tick = ext_rise && (ext_q == EW'(EXT_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_d <= 1'b0;
      ext_d <= 1'b0;
      ext_q <= '0;
    end else begin
      evt_d <= evt_s;
      ext_d <= ext_s;
      if (ext_rise) ext_q <= ext_tick ? '0 : ext_q + 1'b1;
    end
  end

  always_comb begin
    case (sel)
      TB_DIV_SLOW: tick = slow_tick;
      TB_DIV_FAST: tick = fast_tick;
      TB_TPULSE:   tick = tmr_pulse;
      TB_EVT_FALL: tick = evt_fall;
      TB_SYSCLK:   tick = 1'b1;
      TB_EXT_DIV:  tick = ext_tick;
      default:     tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/ectl_modereg.sv
module ectl_modereg
  import ectl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] mode_q
);
  logic [7:0] mode_nxt;
  logic en_now, lk_now;

  assign en_now = mode_q[MB_WDEN];
  assign lk_now = mode_q[MB_LOCK];

  always_comb begin
    mode_nxt          = en_now ? mode_q : wdata;
    mode_nxt[MB_LOCK] = lk_now | wdata[MB_LOCK];
    mode_nxt[MB_WDEN] = lk_now ? (en_now | wdata[MB_WDEN]) : wdata[MB_WDEN];
    mode_nxt[MB_ZERO] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  mode_q <= MODE_RESET;
    else if (wr) mode_q <= mode_nxt;
  end
endmodule

// File: rtl/ectl_counter.sv
module ectl_counter #(
  parameter int CW = 16,
  localparam int NB = CW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [NB-1:0] wr_byte,
  input  logic [7:0]    wdata,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [CW-1:0] cnt_q, cnt_wr;
  logic wrap;

  always_comb begin
    cnt_wr = cnt_q;
    for (int b = 0; b < NB; b++)
      if (wr_byte[b]) cnt_wr[b*8 +: 8] = wdata;
  end

  assign wrap = adv && (wr_byte == '0) && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_byte != '0) cnt_q <= cnt_wr;
      else if (adv)      cnt_q <= cnt_q + 1'b1;
      if (wrap)          ovf <= 1'b1;
      else if (flag_clr) ovf <= 1'b0;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_counter_ctrl.sv
module evt_counter_ctrl
  import ectl_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NB = CNT_W / 8,
  localparam int AW = $clog2(NB + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             tmr_ovf_in,
  input  logic             evt_pin,
  input  logic             ext_clk,
  input  logic             cpu_idle,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wd_enable
);
  localparam logic [AW-1:0] A_MODE = '0;
  localparam logic [AW-1:0] A_FLAG = AW'(NB + 1);

  logic [7:0]    mode_q;
  logic [NB-1:0] wr_byte;
  logic tick, hold, flag_clr;

  ectl_modereg u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr && bus_addr == A_MODE),
    .wdata(bus_wdata), .mode_q(mode_q));

  ectl_timebase #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
    .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .sel(tb_sel_e'(mode_q[3:1])),
    .tmr_pulse(tmr_ovf_in), .evt_pin(evt_pin), .ext_clk(ext_clk),
    .tick(tick));

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_wr
      assign wr_byte[gb] = bus_wr && (bus_addr == AW'(gb + 1));
    end
  endgenerate

  assign hold     = mode_q[MB_IDLE] & cpu_idle;
  assign flag_clr = bus_wr && (bus_addr == A_FLAG) && !bus_wdata[0];

  ectl_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(tick & ~hold), .wr_byte(wr_byte),
    .wdata(bus_wdata), .flag_clr(flag_clr), .count(count), .ovf(ovf_flag));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MODE)      bus_rdata = mode_q;
    else if (bus_addr == A_FLAG) bus_rdata = {7'b0, ovf_flag};
    else
      for (int b = 0; b < NB; b++)
        if (bus_addr == AW'(b + 1)) bus_rdata = count[b*8 +: 8];
  end

  assign irq       = ovf_flag & mode_q[MB_IEN];
  assign wd_enable = mode_q[MB_WDEN];
endmodule

// File: rtl/ectl_chk.sv
module ectl_chk #(
  parameter int AW = 2,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          cpu_idle,
  input logic [CW-1:0] count,
  input logic          ovf_flag,
  input logic          irq,
  input logic          wd_enable,
  input logic [7:0]    mode_q
);
  localparam int NB = CW / 8;
  logic cnt_wr, flag_wipe;
  assign cnt_wr    = bus_wr && bus_addr != '0 && bus_addr <= AW'(NB);
  assign flag_wipe = bus_wr && bus_addr == AW'(NB + 1) && !bus_wdata[0];

  assert_bit4_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> !bus_rdata[4]);
  assert_rsv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b11 && !cnt_wr) |=> $stable(count));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[7] && cpu_idle && !cnt_wr) |=> $stable(count));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_wipe) |=> ovf_flag);
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[6] |=> $stable({mode_q[7], mode_q[3:0]}));
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5] |=> mode_q[5]);
  assert_locked_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5] && wd_enable) |=> wd_enable);
endmodule

bind evt_counter_ctrl ectl_chk #(.AW(AW), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_idle(cpu_idle),
  .count(count), .ovf_flag(ovf_flag), .irq(irq), .wd_enable(wd_enable),
  .mode_q(mode_q));

// File: tb/evt_counter_ctrl_bench.sv
`timescale 1ns/1ps
module evt_counter_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic tmr_ovf_in = 1'b0, evt_pin = 1'b1, ext_clk = 1'b0, cpu_idle = 1'b0;
  logic [15:0] count;
  logic ovf_flag, irq, wd_enable;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_counter_ctrl u_evt_counter_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf_in(tmr_ovf_in),
    .evt_pin(evt_pin), .ext_clk(ext_clk), .cpu_idle(cpu_idle),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .wd_enable(wd_enable));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // park on a reserved select, then load the count
  task automatic set_count(logic [15:0] v);
    wr(2'd0, 8'h0C);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 mode", d, 8'h40);
    rd(2'd3, d); check("R1 flag", d, 8'h00);
    check("R1 count", count, 16'h0000);
    check("R1 irq", irq, 1'b0);
    check("R1 wd_enable", wd_enable, 1'b1);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wr(2'd0, 8'hCF);
    rd(2'd0, d); check("R10 frozen while enabled", d, 8'h40);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R10 enable cleared", d, 8'h00);
    check("R10 wd_enable low", wd_enable, 1'b0);
    wr(2'd0, 8'h9B);
    rd(2'd0, d); check("R2 bit4 reads zero, others taken", d, 8'h8B);
  endtask

  task automatic t_load();
    logic [7:0] d;
    set_count(16'hA5C3);
    check("R12 count port", count, 16'hA5C3);
    rd(2'd1, d); check("R12 low byte", d, 8'hC3);
    rd(2'd2, d); check("R12 high byte", d, 8'hA5);
  endtask

  task automatic t_internal();
    set_count(16'h0000); wr(2'd0, 8'h00); idle(120);
    check("R3 div12", count, 16'd10);
    set_count(16'h0000); wr(2'd0, 8'h02); idle(40);
    check("R3 div4", count, 16'd10);
    set_count(16'h0000); wr(2'd0, 8'h08); idle(50);
    check("R3 sysclk", count, 16'd50);
  endtask

  task automatic t_pulse_rsv();
    logic [7:0] d;
    set_count(16'h0000); wr(2'd0, 8'h04);
    for (int i = 0; i < 7; i++) begin
      tmr_ovf_in = 1'b1; @(negedge clk); tmr_ovf_in = 1'b0; idle(2);
    end
    check("R4 timer pulses", count, 16'd7);
    wr(2'd0, 8'h0E);
    rd(2'd0, d); check("R4 reserved code readback", d, 8'h0E);
    idle(30);
    check("R4 reserved holds", count, 16'd7);
  endtask

  task automatic t_event();
    set_count(16'h0000); wr(2'd0, 8'h06);
    for (int i = 0; i < 6; i++) begin
      evt_pin = 1'b0; idle(2); evt_pin = 1'b1; idle(2);
    end
    idle(5);
    check("R5 falling edges at 1/4 rate", count, 16'd6);
  endtask

  task automatic t_extclk();
    set_count(16'h0000); wr(2'd0, 8'h0A);
    for (int i = 0; i < 16; i++) begin
      ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3);
    end
    idle(5);
    check("R6 sixteen edges", count, 16'd2);
    for (int i = 0; i < 7; i++) begin
      ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3);
    end
    idle(5);
    check("R6 seven more edges", count, 16'd2);
    ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(5);
    check("R6 eighth edge", count, 16'd3);
  endtask

  task automatic t_idle();
    set_count(16'h0000); cpu_idle = 1'b1; wr(2'd0, 8'h88); idle(20);
    check("R7 suspended while idle", count, 16'd0);
    wr(2'd0, 8'h08); idle(20);
    check("R7 idle ignored when bit7 clear", count, 16'd20);
    cpu_idle = 1'b0;
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    set_count(16'hFFFD); wr(2'd0, 8'h09); idle(3);
    check("R8 wrap value", count, 16'h0000);
    check("R8 flag set", ovf_flag, 1'b1);
    check("R9 irq enabled", irq, 1'b1);
    wr(2'd0, 8'h0D);
    wr(2'd3, 8'h01);
    rd(2'd3, d); check("R8 write 1 keeps flag", d, 8'h01);
    wr(2'd3, 8'h00);
    check("R8 write 0 clears flag", ovf_flag, 1'b0);
    check("R9 irq low after clear", irq, 1'b0);
    set_count(16'hFFFF); wr(2'd0, 8'h08); idle(1);
    check("R8 wrap from FFFF", count, 16'h0000);
    check("R9 flag set but masked", {ovf_flag, irq}, 2'b10);
    wr(2'd0, 8'h0C); wr(2'd3, 8'h00);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(2'd0, 8'h60);
    rd(2'd0, d); check("R11 enable and lock", d, 8'h60);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R11 clear refused", d, 8'h60);
    check("R11 wd_enable stays", wd_enable, 1'b1);
    wr(2'd0, 8'h9F);
    rd(2'd0, d); check("R10 others frozen under lock", d, 8'h60);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_protect();
    t_load();
    t_internal();
    t_pulse_rsv();
    t_event();
    t_extclk();
    t_idle();
    t_overflow();
    t_lock();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule